// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small processor core and chooses which of 21 numbered interrupt sources the core services next. Each source has a pending flag and an individual enable, and a global enable gates all sources except source 1. Source 1 is a reset request that no enable can block. The core tells the controller when an instruction has retired (a boundary strobe) and when a handler has returned (a return strobe). When the controller accepts a source at a boundary, it answers one cycle later with a take pulse, a push request for the return address, the number of the chosen source and its vector address.

A build-time mask sets each source as event-latched or condition-following. An event source latches a rising edge of its input and holds it until the source is serviced or software clears it. A condition source only mirrors its input, so a request that goes away before it is serviced is lost. A three-register interface gives software read access to the enables, the pending flags and the global enable, and write access to all three. Pending flags are written with write-one-to-clear.

Top module: `irq_arbiter`

## Requirements
- R1: When more than one source is eligible at a boundary, only the lowest-numbered one is accepted. Source 1 has the highest priority and source 21 the lowest.
- R2: On acceptance of source k, `take_src` reports k and `take_vec` reports 2*(k-1). Source 1 therefore vectors to address 0.
- R3: Source 1 is accepted at any boundary while its flag is pending, whatever the enable bits, the global enable or the post-return hold are set to.
- R4: Sources 2 to 21 are accepted only when the global enable, the source's own enable bit and its pending flag are all set.
- R5: Acceptance happens only in a cycle with `boundary` high. `take` and `push_req` then pulse for exactly one cycle on the next clock, and the global enable reads 0 from that cycle on.
- R6: A `ret` strobe sets the global enable. The first boundary after `ret` accepts no maskable source, and the boundary after that one can.
- R7: An event-type flag (sources 1 to 11, bit i of the pending register is source i+1) is set by a 0-to-1 change on its input even when the source is disabled. It stays set until it is cleared.
- R8: An event-type flag is cleared when its source is accepted, or when a 1 is written to its bit of the pending register. Writing 0 leaves it unchanged.
- R9: A condition-type flag (sources 12 to 21) equals its input delayed by one clock. If the input drops before the source is serviced, no interrupt is taken for it.
- R10: Register address 0 holds the enables (bit i is source i+1), address 1 the pending flags, and address 2 bit 0 the global enable. Read data is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 21 | Source inputs, bit i is source i+1 |
| boundary | input | 1 | Core has retired an instruction this cycle |
| ret | input | 1 | Core executed a return from interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 21 | Write data |
| reg_rdata | output | 21 | Read data |
| take | output | 1 | One-cycle pulse: interrupt accepted |
| push_req | output | 1 | Request to push the current PC |
| take_src | output | 5 | Number of the accepted source |
| take_vec | output | 16 | Vector address of the accepted source |

## Verification
The bench latches two event sources together and checks that they are serviced strictly by number, with the vector of each. A design with the priority reversed would deliver source 5 first. It places a boundary right after a return, where a controller without the hold would re-enter at once, and it checks that the reset source does enter there. It also checks that a flag written with 0 survives, that a latched event survives while disabled, and that a condition which drops before enabling is lost. A design that latched conditions, or that cleared on a zero write, would take a spurious interrupt or lose a real one.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC       = 21,
  parameter int ADDR_W     = 16,
  parameter int VEC_STEP   = 2,
  parameter logic [NSRC-1:0] EVENT_MASK = 21'h0007FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              boundary,
  input  logic              ret,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic              take,
  output logic              push_req,
  output logic [$clog2(NSRC+1)-1:0] take_src,
  output logic [ADDR_W-1:0] take_vec
);
  localparam int IDW = $clog2(NSRC+1);
  localparam logic [NSRC-1:0] EVT  = EVENT_MASK | NSRC'(1);
  localparam logic [NSRC-1:0] NMI  = NSRC'(1);

  logic [NSRC-1:0] ena_q, evt_q, cond_q, src_d;
  logic [NSRC-1:0] pend, elig, clr_mask, w1c;
  logic            gie_q, hold_q, hit, accept;
  logic [IDW-1:0]  win;

  assign pend = evt_q | cond_q;
  assign elig = pend & ((ena_q & {NSRC{gie_q & ~hold_q}}) | NMI);

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (elig[i]) begin
        hit = 1'b1;
        win = IDW'(i);
      end
  end

  assign accept   = boundary & hit;
  assign w1c      = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
  assign clr_mask = w1c | (accept ? (NSRC'(1) << win) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d  <= '0;
      evt_q  <= '0;
      cond_q <= '0;
    end else begin
      src_d  <= src_in;
      evt_q  <= ((evt_q & ~clr_mask) | (src_in & ~src_d)) & EVT;
      cond_q <= src_in & ~EVT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= '0;
    else if (reg_wr && reg_addr == 2'd0) ena_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else if (accept) gie_q <= 1'b0;
    else if (ret) gie_q <= 1'b1;
    else if (reg_wr && reg_addr == 2'd2) gie_q <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else if (ret) hold_q <= 1'b1;
    else if (boundary) hold_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      take_src <= '0;
      take_vec <= '0;
    end else begin
      take <= accept;
      if (accept) begin
        take_src <= win + IDW'(1);
        take_vec <= ADDR_W'(win) * ADDR_W'(VEC_STEP);
      end
    end
  end

  assign push_req = take;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ena_q;
      2'd1:    reg_rdata = pend;
      2'd2:    reg_rdata = NSRC'(gie_q);
      default: reg_rdata = '0;
    endcase
  end

  assert_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));
  assert_gie_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !gie_q);
  assert_hold_after_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !evt_q[0]) |=> !take);
  assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && evt_q[0]) |=> (take && take_src == IDW'(1)));
  assert_cond_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cond_q == ($past(src_in) & ~EVT)));
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic        clk = 0, rst_n = 0;
  logic [20:0] src_in = '0;
  logic        boundary = 0, ret = 0, reg_wr = 0;
  logic [1:0]  reg_addr = '0;
  logic [20:0] reg_wdata = '0;
  logic [20:0] reg_rdata;
  logic        take, push_req;
  logic [4:0]  take_src;
  logic [15:0] take_vec;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  irq_arbiter u0 (.clk(clk), .rst_n(rst_n), .src_in(src_in), .boundary(boundary),
    .ret(ret), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .take(take), .push_req(push_req),
    .take_src(take_src), .take_vec(take_vec));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [20:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [20:0] d);
    @(negedge clk); reg_addr = a; #0.5 d = reg_rdata;
  endtask

  task automatic pulse_src(input logic [20:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
    @(negedge clk);
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1;
    @(negedge clk); ret = 0;
  endtask

  task automatic step(output logic t, output logic p, output logic [4:0] s, output logic [15:0] v);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    t = take; p = push_req; s = take_src; v = take_vec;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [20:0] d;
    chk("R5 take idle after reset", take, 0);
    rd(2'd0, d); chk("R10 enables reset", d, 0);
    rd(2'd1, d); chk("R10 pending reset", d, 0);
    rd(2'd2, d); chk("R10 gie reset", d, 0);
  endtask

  task automatic t_event_latch();
    logic [20:0] d; logic t, p; logic [4:0] s; logic [15:0] v;
    pulse_src(21'h2);
    rd(2'd1, d); chk("R7 event latched while disabled", d[1], 1);
    step(t, p, s, v); chk("R4 no take when disabled", t, 0);
    rd(2'd1, d); chk("R7 flag held", d[1], 1);
    wr(2'd1, 21'h0);
    rd(2'd1, d); chk("R8 write zero no effect", d[1], 1);
    wr(2'd1, 21'h2);
    rd(2'd1, d); chk("R8 write one clears", d[1], 0);
  endtask

  task automatic t_take();
    logic [20:0] d; logic t, p; logic [4:0] s; logic [15:0] v;
    pulse_src(21'h2);
    wr(2'd0, 21'h2);
    step(t, p, s, v); chk("R4 no take without gie", t, 0);
    wr(2'd2, 21'h1);
    step(t, p, s, v);
    chk("R5 take pulse", t, 1); chk("R5 push_req", p, 1);
    chk("R2 source id 2", s, 2); chk("R2 vector 2", v, 2);
    chk("R5 take one cycle", take, 0);
    rd(2'd2, d); chk("R5 gie cleared", d[0], 0);
    rd(2'd1, d); chk("R8 cleared on take", d[1], 0);
  endtask

  task automatic t_prio();
    logic [20:0] d; logic t, p; logic [4:0] s; logic [15:0] v;
    wr(2'd0, 21'h12);
    pulse_src(21'h12);
    do_ret();
    rd(2'd2, d); chk("R6 ret sets gie", d[0], 1);
    step(t, p, s, v); chk("R6 hold boundary after ret", t, 0);
    step(t, p, s, v);
    chk("R1 lowest number wins", s, 2); chk("R1 take", t, 1);
    rd(2'd1, d); chk("R1 loser still pending", d[4], 1);
    do_ret();
    step(t, p, s, v); chk("R6 hold again", t, 0);
    step(t, p, s, v);
    chk("R2 source 5 id", s, 5); chk("R2 source 5 vector", v, 8);
  endtask

  task automatic t_cond();
    logic [20:0] d; logic t, p; logic [4:0] s; logic [15:0] v;
    wr(2'd0, 21'h4000);
    @(negedge clk); src_in[14] = 1;
    @(negedge clk);
    rd(2'd1, d); chk("R9 condition follows high", d[14], 1);
    @(negedge clk); src_in[14] = 0;
    @(negedge clk);
    rd(2'd1, d); chk("R9 condition follows low", d[14], 0);
    wr(2'd2, 21'h1);
    step(t, p, s, v); chk("R9 dropped condition lost", t, 0);
    @(negedge clk); src_in[14] = 1;
    @(negedge clk);
    step(t, p, s, v);
    chk("R9 condition taken", t, 1); chk("R2 source 15 vector", v, 28);
    chk("R2 source 15 id", s, 15);
    @(negedge clk); src_in[14] = 0;
  endtask

  task automatic t_reset_src();
    logic t, p; logic [4:0] s; logic [15:0] v;
    wr(2'd0, 21'h0);
    wr(2'd2, 21'h0);
    pulse_src(21'h1);
    step(t, p, s, v);
    chk("R3 reset source unmaskable", t, 1);
    chk("R2 reset vector 0", v, 0); chk("R3 reset id", s, 1);
    pulse_src(21'h1);
    do_ret();
    step(t, p, s, v);
    chk("R3 reset ignores hold", t, 1); chk("R3 reset id after ret", s, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_event_latch();
    t_take();
    t_prio();
    t_cond();
    t_reset_src();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule